// File: doc/BRIEF.md
# Flash Erase Command Sequencer

This block sits on the device side of an asynchronous memory bus and watches for the write-cycle sequence that asks a flash array to erase itself. The bus lines (address, byte-wide write data, chip enable, write enable, output enable and a bus reset) are sampled in the system clock domain. The write strobe is the time that chip enable and write enable are both low. A short synchronizer chain detects when that strobe is asserted and when it is released.

Five unlock and setup writes must come first. A sixth write then names the erase: a single sector, a whole block, or the entire array. The target address is taken when the sixth strobe is asserted, and the command byte when it is released. The block then raises a one-cycle start strobe and a busy flag, and reports the erase kind and target address. A down-counter models how long the erase takes. When that count runs out, busy drops and the affected words of a small register array become all ones.

The array is scaled down by parameters. A block always holds 32 sectors, but the sector size and the number of blocks can be shrunk for simulation. A read port returns array words so that the bench can observe the effect of each erase.

Top module: `flash_erase_seq`

## Requirements
- R1: After system reset, busy, erase_start and erase_kind are 0, and array word i holds 16'h8000 | i.
- R2: An erase command needs five writes before it, in this order: addr 5555h/data AAh, 2AAAh/55h, 5555h/80h, 5555h/AAh, 2AAAh/55h. The full 16-bit address and the write byte must both match.
- R3: A sixth write with data 30h erases the 4-word sector holding the target address (address bits [7:2] select the sector) and reports erase_kind 2'b01.
- R4: A sixth write with data 50h erases the 128-word block holding the target address (address bit [7] selects the block) and reports erase_kind 2'b10.
- R5: A sixth write with data 10h at address 5555h erases every word and reports erase_kind 2'b11. Data 10h at any other address starts nothing.
- R6: The target address is the one present when the sixth strobe is asserted. An address change while the strobe is still low has no effect on erase_addr or on which words are erased.
- R7: erase_start is a single-cycle pulse. It rises in the same cycle as busy, on the third clock edge after the sixth strobe is released, and is low on the second.
- R8: busy stays high for exactly ERASE_CYCLES clocks (default 200). The erased words read as FFFFh once busy has fallen.
- R9: Writes that arrive while busy is high are ignored. They cause no new start, leave erase_addr and erase_kind unchanged, and erase no words.
- R10: A mismatch in any of the first five writes, or an unknown sixth data byte, returns the sequence to its start and erases nothing.
- R11: Pulling the bus reset low partway through a sequence returns it to its start, so the remaining writes start nothing.
- R12: mem_rdata returns the word at mem_addr[7:0] while chip enable and output enable are both low, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | System reset, active low |
| mem_addr | input | 16 | Bus address |
| mem_wdata | input | 8 | Bus write byte |
| mem_ce_n | input | 1 | Chip enable, active low |
| mem_we_n | input | 1 | Write enable, active low |
| mem_oe_n | input | 1 | Output enable, active low |
| mem_rst_n | input | 1 | Bus reset, active low |
| mem_rdata | output | 16 | Array read data |
| erase_start | output | 1 | One-cycle pulse when an erase begins |
| erase_kind | output | 2 | 01 sector, 10 block, 11 whole array |
| erase_addr | output | 16 | Latched target address |
| busy | output | 1 | High while an erase is running |

## Verification
The start pulse and busy are due on the third rising edge after the sixth strobe is released. The bench therefore counts exactly those edges and samples at the falling edge after the second and after the third, expecting low and then high. Busy is measured by counting falling-edge samples until it drops, and the total must equal ERASE_CYCLES. The array is read back through the combinational read port only after busy is low. The bench drives every bus change on a falling clock edge, and it holds address and data for several cycles around each strobe edge so that the captures happen where the requirements place them.

// File: rtl/fes_pkg.sv
package fes_pkg;

    typedef enum logic [1:0] {
        KIND_NONE   = 2'b00,
        KIND_SECTOR = 2'b01,
        KIND_BLOCK  = 2'b10,
        KIND_CHIP   = 2'b11
    } erase_kind_e;

    localparam logic [15:0] ADDR_LO = 16'h5555;
    localparam logic [15:0] ADDR_HI = 16'h2AAA;

    localparam logic [7:0] CODE_SECTOR = 8'h30;
    localparam logic [7:0] CODE_BLOCK  = 8'h50;
    localparam logic [7:0] CODE_CHIP   = 8'h10;

    localparam int unsigned PREFIX_LEN = 5;

    // expected address of prefix write number step (0-based)
    function automatic logic [15:0] prefix_addr(input logic [2:0] step);
        case (step)
            3'd1, 3'd4: prefix_addr = ADDR_HI;
            default:    prefix_addr = ADDR_LO;
        endcase
    endfunction

    // expected byte of prefix write number step (0-based)
    function automatic logic [7:0] prefix_data(input logic [2:0] step);
        case (step)
            3'd1, 3'd4: prefix_data = 8'h55;
            3'd2:       prefix_data = 8'h80;
            default:    prefix_data = 8'hAA;
        endcase
    endfunction

endpackage

// File: rtl/fes_bus_sync.sv
module fes_bus_sync #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic we_n,
    input  logic bus_rst_n,
    output logic strobe_on,
    output logic strobe_off,
    output logic bus_rst
);
    localparam int unsigned CHAIN = SYNC_STAGES + 1;

    typedef struct packed {
        logic [CHAIN-1:0]       strb;
        logic [SYNC_STAGES-1:0] rst;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.strb = {s_q.strb[CHAIN-2:0], (~ce_n & ~we_n)};
        s_d.rst  = {s_q.rst[SYNC_STAGES-2:0], bus_rst_n};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign strobe_on  =  s_q.strb[CHAIN-2] & ~s_q.strb[CHAIN-1];
    assign strobe_off = ~s_q.strb[CHAIN-2] &  s_q.strb[CHAIN-1];
    assign bus_rst    = ~s_q.rst[SYNC_STAGES-1];

endmodule

// File: rtl/fes_cmd_decoder.sv
module fes_cmd_decoder
    import fes_pkg::*;
#(
    parameter int unsigned AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strobe_on,
    input  logic          strobe_off,
    input  logic          bus_rst,
    input  logic          busy_i,
    input  logic [AW-1:0] addr_i,
    input  logic [7:0]    data_i,
    output logic          go_o,
    output erase_kind_e   kind_o,
    output logic [AW-1:0] addr_o
);
    typedef struct packed {
        logic [2:0]    step;
        logic [AW-1:0] cap_addr;
    } dec_t;

    dec_t d_d, d_q;
    logic go_d;
    erase_kind_e kind_d;

    always_comb begin
        d_d    = d_q;
        go_d   = 1'b0;
        kind_d = KIND_NONE;
        if (bus_rst || busy_i) begin
            d_d.step = '0;
        end else begin
            if (strobe_on) d_d.cap_addr = addr_i;
            if (strobe_off) begin
                if (d_q.step < 3'(PREFIX_LEN)) begin
                    if (d_q.cap_addr == AW'(prefix_addr(d_q.step)) &&
                        data_i == prefix_data(d_q.step))
                        d_d.step = d_q.step + 3'd1;
                    else
                        d_d.step = '0;
                end else begin
                    d_d.step = '0;
                    case (data_i)
                        CODE_SECTOR: begin go_d = 1'b1; kind_d = KIND_SECTOR; end
                        CODE_BLOCK:  begin go_d = 1'b1; kind_d = KIND_BLOCK;  end
                        CODE_CHIP: begin
                            if (d_q.cap_addr == AW'(ADDR_LO)) begin
                                go_d   = 1'b1;
                                kind_d = KIND_CHIP;
                            end
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) d_q <= '0;
        else        d_q <= d_d;
    end

    assign go_o   = go_d;
    assign kind_o = kind_d;
    assign addr_o = d_q.cap_addr;

    // R9
    busy_blocks_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go_o |-> !busy_i);

    // R2
    step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        d_q.step <= 3'(PREFIX_LEN));

    // R11
    bus_rst_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst |=> d_q.step == 3'd0);

endmodule

// File: rtl/fes_erase_engine.sv
module fes_erase_engine
    import fes_pkg::*;
#(
    parameter int unsigned AW           = 16,
    parameter int unsigned DW           = 16,
    parameter int unsigned SECTOR_WORDS = 4,
    parameter int unsigned BLOCK_WORDS  = 128,
    parameter int unsigned WORDS        = 256,
    parameter int unsigned ERASE_CYCLES = 200
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go_i,
    input  erase_kind_e   kind_i,
    input  logic [AW-1:0] addr_i,
    input  logic [AW-1:0] rd_addr,
    output logic          start_o,
    output logic          busy_o,
    output logic [1:0]    kind_o,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] rd_word
);
    localparam int unsigned IDXW = $clog2(WORDS);
    localparam int unsigned SECW = $clog2(SECTOR_WORDS);
    localparam int unsigned BLKW = $clog2(BLOCK_WORDS);
    localparam int unsigned CNTW = $clog2(ERASE_CYCLES + 1);

    typedef struct packed {
        logic                      busy;
        logic                      start;
        erase_kind_e               kind;
        logic [AW-1:0]             addr;
        logic [CNTW-1:0]           cnt;
        logic [WORDS-1:0][DW-1:0]  mem;
    } eng_t;

    eng_t e_d, e_q;

    function automatic eng_t reset_state();
        eng_t s;
        s = '0;
        for (int i = 0; i < WORDS; i++)
            s.mem[i] = DW'(i) | (DW'(1) << (DW - 1));
        return s;
    endfunction

    function automatic logic word_hit(input int idx, input erase_kind_e k,
                                      input logic [IDXW-1:0] tgt);
        logic [IDXW-1:0] w;
        w = IDXW'(idx);
        case (k)
            KIND_SECTOR: word_hit = (w >> SECW) == (tgt >> SECW);
            KIND_BLOCK:  word_hit = (w >> BLKW) == (tgt >> BLKW);
            KIND_CHIP:   word_hit = 1'b1;
            default:     word_hit = 1'b0;
        endcase
    endfunction

    always_comb begin
        e_d       = e_q;
        e_d.start = 1'b0;
        if (e_q.busy) begin
            if (e_q.cnt == '0) begin
                e_d.busy = 1'b0;
                for (int i = 0; i < WORDS; i++)
                    if (word_hit(i, e_q.kind, e_q.addr[IDXW-1:0]))
                        e_d.mem[i] = '1;
            end else begin
                e_d.cnt = e_q.cnt - CNTW'(1);
            end
        end else if (go_i) begin
            e_d.busy  = 1'b1;
            e_d.start = 1'b1;
            e_d.kind  = kind_i;
            e_d.addr  = addr_i;
            e_d.cnt   = CNTW'(ERASE_CYCLES - 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= reset_state();
        else        e_q <= e_d;
    end

    logic          busy_q;
    logic          start_q;
    logic [AW-1:0] addr_q;
    logic [CNTW-1:0] cnt_q;

    assign busy_q  = e_q.busy;
    assign start_q = e_q.start;
    assign addr_q  = e_q.addr;
    assign cnt_q   = e_q.cnt;

    assign start_o = start_q;
    assign busy_o  = busy_q;
    assign kind_o  = e_q.kind;
    assign addr_o  = addr_q;
    assign rd_word = e_q.mem[rd_addr[IDXW-1:0]];

    // R7
    start_with_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |-> busy_q);

    // R7
    start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |=> !start_q);

    // R8
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> $past(cnt_q) == '0);

    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && cnt_q != '0) |=> busy_q);

    // R9
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !start_q) |-> $stable(addr_q));

    // R3
    kind_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> e_q.kind != KIND_NONE);

endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
    import fes_pkg::*;
#(
    parameter int unsigned AW            = 16,
    parameter int unsigned DW            = 16,
    parameter int unsigned SECTOR_WORDS  = 4,
    parameter int unsigned BLOCK_SECTORS = 32,
    parameter int unsigned NUM_BLOCKS    = 2,
    parameter int unsigned ERASE_CYCLES  = 200,
    parameter int unsigned SYNC_STAGES   = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] mem_addr,
    input  logic [7:0]    mem_wdata,
    input  logic          mem_ce_n,
    input  logic          mem_we_n,
    input  logic          mem_oe_n,
    input  logic          mem_rst_n,
    output logic [DW-1:0] mem_rdata,
    output logic          erase_start,
    output logic [1:0]    erase_kind,
    output logic [AW-1:0] erase_addr,
    output logic          busy
);
    localparam int unsigned BLOCK_WORDS = SECTOR_WORDS * BLOCK_SECTORS;
    localparam int unsigned WORDS       = BLOCK_WORDS * NUM_BLOCKS;

    logic          strobe_on, strobe_off, bus_rst;
    logic          go;
    erase_kind_e   go_kind;
    logic [AW-1:0] go_addr;
    logic [DW-1:0] rd_word;

    fes_bus_sync #(
        .SYNC_STAGES(SYNC_STAGES)
    ) sync_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_n      (mem_ce_n),
        .we_n      (mem_we_n),
        .bus_rst_n (mem_rst_n),
        .strobe_on (strobe_on),
        .strobe_off(strobe_off),
        .bus_rst   (bus_rst)
    );

    fes_cmd_decoder #(
        .AW(AW)
    ) dec_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe_on (strobe_on),
        .strobe_off(strobe_off),
        .bus_rst   (bus_rst),
        .busy_i    (busy),
        .addr_i    (mem_addr),
        .data_i    (mem_wdata),
        .go_o      (go),
        .kind_o    (go_kind),
        .addr_o    (go_addr)
    );

    fes_erase_engine #(
        .AW          (AW),
        .DW          (DW),
        .SECTOR_WORDS(SECTOR_WORDS),
        .BLOCK_WORDS (BLOCK_WORDS),
        .WORDS       (WORDS),
        .ERASE_CYCLES(ERASE_CYCLES)
    ) eng_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .go_i   (go),
        .kind_i (go_kind),
        .addr_i (go_addr),
        .rd_addr(mem_addr),
        .start_o(erase_start),
        .busy_o (busy),
        .kind_o (erase_kind),
        .addr_o (erase_addr),
        .rd_word(rd_word)
    );

    assign mem_rdata = (!mem_ce_n && !mem_oe_n) ? rd_word : '0;

endmodule

// File: tb/flash_erase_seq_tb.sv
`timescale 1ns/1ps
module flash_erase_seq_tb_top;

    localparam int unsigned E_CYC = 200;
    localparam int unsigned NW    = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mem_addr = '0;
    logic [7:0]  mem_wdata = '0;
    logic        mem_ce_n = 1'b1;
    logic        mem_we_n = 1'b1;
    logic        mem_oe_n = 1'b1;
    logic        mem_rst_n = 1'b1;
    logic [15:0] mem_rdata;
    logic        erase_start;
    logic [1:0]  erase_kind;
    logic [15:0] erase_addr;
    logic        busy;

    int n_chk = 0;
    int n_fail = 0;
    int start_cnt = 0;
    logic [15:0] exp_mem [NW];

    always #4 clk = ~clk;

    flash_erase_seq dut_i (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_rst_n(mem_rst_n), .mem_rdata(mem_rdata), .erase_start(erase_start),
        .erase_kind(erase_kind), .erase_addr(erase_addr), .busy(busy)
    );

    always @(negedge clk) if (rst_n && erase_start) start_cnt++;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        mem_addr = a; mem_wdata = d; mem_ce_n = 1'b0; mem_we_n = 1'b0;
        repeat (8) @(negedge clk);
        mem_we_n = 1'b1;
        repeat (5) @(negedge clk);
        mem_ce_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic unlock();
        bus_write(16'h5555, 8'hAA);
        bus_write(16'h2AAA, 8'h55);
        bus_write(16'h5555, 8'h80);
        bus_write(16'h5555, 8'hAA);
        bus_write(16'h2AAA, 8'h55);
    endtask

    // sixth write with edge-exact timing checks; returns at the negedge after edge 3
    task automatic sixth(input logic [15:0] a, input logic [7:0] d,
                         input bit late, input logic [15:0] late_a);
        @(negedge clk);
        mem_addr = a; mem_wdata = d; mem_ce_n = 1'b0; mem_we_n = 1'b0;
        repeat (6) @(negedge clk);
        if (late) mem_addr = late_a;
        repeat (2) @(negedge clk);
        mem_we_n = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        check(erase_start == 1'b0, "R7", "start before third edge", erase_start, 0);
        @(posedge clk);
        @(negedge clk);
        check(erase_start == 1'b1, "R7", "start on third edge", erase_start, 1);
        check(busy == 1'b1, "R7", "busy with start", busy, 1);
        mem_ce_n = 1'b1;
    endtask

    task automatic measure_busy(output int n);
        n = 0;
        while (busy && n < 100000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic check_mem(input string req);
        int bad = 0;
        logic [15:0] first_act = '0, first_exp = '0;
        mem_ce_n = 1'b0; mem_oe_n = 1'b0;
        for (int i = 0; i < NW; i++) begin
            mem_addr = 16'(i);
            #0.01;
            if (mem_rdata !== exp_mem[i]) begin
                if (bad == 0) begin first_act = mem_rdata; first_exp = exp_mem[i]; end
                bad++;
            end
        end
        mem_oe_n = 1'b1; mem_ce_n = 1'b1;
        check(bad == 0, req, "array contents", first_act, first_exp);
    endtask

    task automatic t_reset();
        for (int i = 0; i < NW; i++) exp_mem[i] = 16'h8000 | 16'(i);
        check(busy == 1'b0, "R1", "busy after reset", busy, 0);
        check(erase_start == 1'b0, "R1", "start after reset", erase_start, 0);
        check(erase_kind == 2'b00, "R1", "kind after reset", erase_kind, 0);
        check_mem("R1");
    endtask

    task automatic t_read_gate();
        mem_addr = 16'h0003; mem_ce_n = 1'b0; mem_oe_n = 1'b1;
        #0.01;
        check(mem_rdata == 16'h0000, "R12", "oe high read", mem_rdata, 0);
        mem_oe_n = 1'b0;
        #0.01;
        check(mem_rdata == 16'h8003, "R12", "enabled read", mem_rdata, 16'h8003);
        mem_ce_n = 1'b1;
        #0.01;
        check(mem_rdata == 16'h0000, "R12", "ce high read", mem_rdata, 0);
        mem_oe_n = 1'b1;
    endtask

    task automatic t_sector();
        int n, s0;
        s0 = start_cnt;
        unlock();
        sixth(16'h0005, 8'h30, 1'b1, 16'h0040);
        check(erase_kind == 2'b01, "R3", "sector kind", erase_kind, 1);
        check(erase_addr == 16'h0005, "R6", "address from assertion edge", erase_addr, 16'h0005);
        measure_busy(n);
        check(n == E_CYC, "R8", "busy length", n, E_CYC);
        check(start_cnt == s0 + 1, "R7", "single start pulse", start_cnt - s0, 1);
        for (int i = 4; i < 8; i++) exp_mem[i] = 16'hFFFF;
        check_mem("R3");
    endtask

    task automatic t_mismatch();
        int s0;
        s0 = start_cnt;
        bus_write(16'h5555, 8'hAA);
        bus_write(16'h2AAA, 8'h55);
        bus_write(16'h5555, 8'h90);
        bus_write(16'h5555, 8'hAA);
        bus_write(16'h2AAA, 8'h55);
        bus_write(16'h0010, 8'h30);
        check(start_cnt == s0 && !busy, "R10", "prefix mismatch start", start_cnt - s0, 0);
        unlock();
        bus_write(16'h0010, 8'h20);
        check(start_cnt == s0 && !busy, "R10", "unknown code start", start_cnt - s0, 0);
        check(erase_addr == 16'h0005, "R10", "addr untouched", erase_addr, 16'h0005);
        check_mem("R10");
    endtask

    task automatic t_bus_reset();
        int s0;
        s0 = start_cnt;
        bus_write(16'h5555, 8'hAA);
        bus_write(16'h2AAA, 8'h55);
        bus_write(16'h5555, 8'h80);
        mem_rst_n = 1'b0;
        repeat (6) @(negedge clk);
        mem_rst_n = 1'b1;
        repeat (4) @(negedge clk);
        bus_write(16'h5555, 8'hAA);
        bus_write(16'h2AAA, 8'h55);
        bus_write(16'h0010, 8'h30);
        check(start_cnt == s0 && !busy, "R11", "start after bus reset", start_cnt - s0, 0);
        check_mem("R11");
    endtask

    task automatic t_block_and_ignore();
        int n, s0;
        s0 = start_cnt;
        unlock();
        sixth(16'h0085, 8'h50, 1'b0, 16'h0000);
        check(erase_kind == 2'b10, "R4", "block kind", erase_kind, 2);
        check(erase_addr == 16'h0085, "R4", "block addr", erase_addr, 16'h0085);
        fork
            measure_busy(n);
            begin
                unlock();
                bus_write(16'h0010, 8'h30);
            end
        join
        check(n == E_CYC, "R8", "busy length under traffic", n, E_CYC);
        check(start_cnt == s0 + 1, "R9", "no start while busy", start_cnt - s0, 1);
        check(erase_addr == 16'h0085, "R9", "addr kept", erase_addr, 16'h0085);
        check(erase_kind == 2'b10, "R9", "kind kept", erase_kind, 2);
        for (int i = 128; i < 256; i++) exp_mem[i] = 16'hFFFF;
        check_mem("R4");
    endtask

    task automatic t_chip();
        int n, s0;
        s0 = start_cnt;
        unlock();
        bus_write(16'h1234, 8'h10);
        check(start_cnt == s0 && !busy, "R5", "chip code off address", start_cnt - s0, 0);
        unlock();
        sixth(16'h5555, 8'h10, 1'b0, 16'h0000);
        check(erase_kind == 2'b11, "R5", "chip kind", erase_kind, 3);
        measure_busy(n);
        check(n == E_CYC, "R8", "chip busy length", n, E_CYC);
        for (int i = 0; i < NW; i++) exp_mem[i] = 16'hFFFF;
        check_mem("R5");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_read_gate();
        t_sector();
        t_mismatch();
        t_bus_reset();
        t_block_and_ignore();
        t_chip();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule